// File: doc/BRIEF.md
# Management packet receive classifier

This block sits in a network receive path, after an upstream matcher that has already flagged some frames as management traffic. It reads a byte stream with start and end markers, a per-frame management flag and the current power state, and decides for each frame how the host should receive it. The flag and the power state are both taken on the first byte of the frame.

While the system is powered up, every frame goes on to the host through the normal receive path with one cycle of latency. A frame carries a descriptor status word that is valid on its last byte. For a management frame, that word has a management bit set and a fixed port identifier in its low field.

While the system is powered down, ordinary frames are discarded. A management frame instead becomes a wake-up event. Its leading bytes go into a capture buffer, up to a fixed prefix length, and the active-low wake request is driven low. The wake request stays low until the host sends a clear pulse. The host reads back the captured length and the buffer contents through a registered read port.

Top module: `mgmt_rx_classifier`

## Requirements
- R1: With `pwr_down` low at the first byte, each input beat appears on `out_valid`/`out_data`/`out_sof`/`out_eof` exactly one clock later, byte for byte, with its markers unchanged.
- R2: On the last beat of a forwarded management frame, `desc_valid` is 1 and `desc_status` is 0x010A: bit 8 (management flag) is set, bits 3:0 hold the management port 0xA, and all other bits are 0. `desc_valid` is high only together with `out_valid` and `out_eof`.
- R3: On the last beat of a forwarded non-management frame, `desc_valid` is 1 and `desc_status` is 0x0000.
- R4: A management frame that arrives while powered down is not forwarded: `out_valid` and `desc_valid` stay 0 for all of its beats.
- R5: `pme_n` goes low one clock after the last beat of a powered-down management frame. It then stays low until `pme_clr` is seen, and goes high one clock after `pme_clr`. A frame end that sets the request wins over a clear in the same cycle.
- R6: The first CAP_LEN bytes (120 by default) of a wake frame are stored at addresses 0 upward. `cap_rd_data` shows the byte at `cap_rd_addr` one clock after the address is applied.
- R7: `cap_len` becomes min(frame length, CAP_LEN) in the same clock that `pme_n` goes low, and never exceeds CAP_LEN.
- R8: A non-management frame that arrives while powered down is dropped. It produces no output beats, `pme_n` does not change, and `cap_len` and the buffer contents do not change.
- R9: A change of `pwr_down` or `in_mgmt` after the first beat of a frame does not change how that frame is handled.
- R10: While `pme_n` is low, further powered-down management frames are dropped. `cap_len` and the buffer keep the earlier capture.
- R11: After reset, `pme_n` is 1, `out_valid` is 0, `desc_valid` is 0 and `cap_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | DATA_W | Input byte |
| in_sof | input | 1 | First beat of frame |
| in_eof | input | 1 | Last beat of frame |
| in_mgmt | input | 1 | Frame is a management packet (sampled at first beat) |
| pwr_down | input | 1 | Powered-down state (sampled at first beat) |
| pme_clr | input | 1 | Host pulse releasing the wake request |
| cap_rd_addr | input | $clog2(CAP_LEN) | Capture buffer read address |
| out_valid | output | 1 | Forwarded beat valid |
| out_data | output | DATA_W | Forwarded byte |
| out_sof | output | 1 | Forwarded first beat |
| out_eof | output | 1 | Forwarded last beat |
| desc_valid | output | 1 | Descriptor status valid |
| desc_status | output | STAT_W | Receive descriptor status word |
| pme_n | output | 1 | Active-low wake request |
| cap_len | output | $clog2(CAP_LEN+1) | Number of captured bytes |
| cap_rd_data | output | DATA_W | Capture buffer read data |

## Verification
The bench builds the block with CAP_LEN set to 8 and leaves the other parameters at their defaults. With that setting, a sweep of frame lengths from 1 to 12 covers frames shorter than the prefix, exactly equal to it, and longer than it. The sweep runs every length against both values of the management flag and both power states. This brings truncation and the length report within reach in a few hundred cycles. Further directed frames cover the following cases:
- a power-state flip in the middle of a frame;
- a second wake frame while a request is still pending;
- a clear pulse that lands on a wake frame's last byte.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [1:0] {
    MODE_DROP = 2'd0,
    MODE_FWD  = 2'd1,
    MODE_WAKE = 2'd2
  } frame_mode_e;
endpackage

// File: rtl/mrc_cap_ram.sv
module mrc_cap_ram #(
  parameter int DEPTH  = 120,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/mrc_fwd_path.sv
module mrc_fwd_path #(
  parameter int                DATA_W    = 8,
  parameter int                STAT_W    = 16,
  parameter int                MGMT_BIT  = 8,
  parameter int                PORT_LSB  = 0,
  parameter int                PORT_W    = 4,
  parameter logic [PORT_W-1:0] MGMT_PORT = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic [DATA_W-1:0] data,
  input  logic              sof,
  input  logic              eof,
  input  logic              mgmt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              desc_valid,
  output logic [STAT_W-1:0] desc_status
);
  logic [STAT_W-1:0] status_word;

  always_comb begin
    status_word = '0;
    if (mgmt) begin
      status_word[MGMT_BIT]               = 1'b1;
      status_word[PORT_LSB +: PORT_W]     = MGMT_PORT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      desc_valid  <= 1'b0;
      desc_status <= '0;
    end else begin
      out_valid  <= beat;
      out_data   <= data;
      out_sof    <= beat && sof;
      out_eof    <= beat && eof;
      desc_valid <= beat && eof;
      if (beat && eof) desc_status <= status_word;
    end
  end
endmodule

// File: rtl/mrc_wake_capture.sv
module mrc_wake_capture #(
  parameter int  CAP_LEN = 120,
  parameter int  DATA_W  = 8,
  localparam int AW      = $clog2(CAP_LEN),
  localparam int CNT_W   = $clog2(CAP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              sof,
  input  logic              eof,
  input  logic [DATA_W-1:0] data,
  input  logic              pme_clr,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pme_n,
  output logic              pending,
  output logic [CNT_W-1:0]  cap_len
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CAP_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             room;
  logic             pend_q;

  assign idx     = sof ? '0 : cnt_q;
  assign room    = idx < LIMIT;
  assign pending = pend_q;
  assign pme_n   = ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cap_len <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (beat) cnt_q <= room ? idx + 1'b1 : idx;
      if (beat && eof) begin
        cap_len <= room ? idx + 1'b1 : LIMIT;
        pend_q  <= 1'b1;
      end else if (pme_clr) begin
        pend_q  <= 1'b0;
      end
    end
  end

  mrc_cap_ram #(.DEPTH(CAP_LEN), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .wr_en   (beat && room),
    .wr_addr (AW'(idx)),
    .wr_data (data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/mgmt_rx_classifier.sv
module mgmt_rx_classifier
  import mrc_pkg::*;
#(
  parameter int                CAP_LEN   = 120,
  parameter int                DATA_W    = 8,
  parameter int                STAT_W    = 16,
  parameter int                MGMT_BIT  = 8,
  parameter int                PORT_LSB  = 0,
  parameter int                PORT_W    = 4,
  parameter logic [PORT_W-1:0] MGMT_PORT = 4'hA
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          in_sof,
  input  logic                          in_eof,
  input  logic                          in_mgmt,
  input  logic                          pwr_down,
  input  logic                          pme_clr,
  input  logic [$clog2(CAP_LEN)-1:0]    cap_rd_addr,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic                          out_sof,
  output logic                          out_eof,
  output logic                          desc_valid,
  output logic [STAT_W-1:0]             desc_status,
  output logic                          pme_n,
  output logic [$clog2(CAP_LEN+1)-1:0]  cap_len,
  output logic [DATA_W-1:0]             cap_rd_data
);
  frame_mode_e mode_q, beat_mode;
  logic        mgmt_q, beat_mgmt;
  logic        wake_pending;

  always_comb begin
    beat_mode = mode_q;
    beat_mgmt = mgmt_q;
    if (in_sof) begin
      beat_mgmt = in_mgmt;
      if (!pwr_down)                        beat_mode = MODE_FWD;
      else if (in_mgmt && !wake_pending)    beat_mode = MODE_WAKE;
      else                                  beat_mode = MODE_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_DROP;
      mgmt_q <= 1'b0;
    end else if (in_valid) begin
      mode_q <= in_eof ? MODE_DROP : beat_mode;
      mgmt_q <= beat_mgmt;
    end
  end

  mrc_fwd_path #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .MGMT_BIT(MGMT_BIT),
    .PORT_LSB(PORT_LSB), .PORT_W(PORT_W), .MGMT_PORT(MGMT_PORT)
  ) u_fwd (
    .clk         (clk),
    .rst         (rst),
    .beat        (in_valid && beat_mode == MODE_FWD),
    .data        (in_data),
    .sof         (in_sof),
    .eof         (in_eof),
    .mgmt        (beat_mgmt),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .desc_valid  (desc_valid),
    .desc_status (desc_status)
  );

  mrc_wake_capture #(.CAP_LEN(CAP_LEN), .DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .beat    (in_valid && beat_mode == MODE_WAKE),
    .sof     (in_sof),
    .eof     (in_eof),
    .data    (in_data),
    .pme_clr (pme_clr),
    .rd_addr (cap_rd_addr),
    .rd_data (cap_rd_data),
    .pme_n   (pme_n),
    .pending (wake_pending),
    .cap_len (cap_len)
  );
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int CAP_LEN = 120,
  parameter int STAT_W  = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         in_eof,
  input logic                         pme_clr,
  input logic                         out_valid,
  input logic                         out_eof,
  input logic                         desc_valid,
  input logic [STAT_W-1:0]            desc_status,
  input logic                         pme_n,
  input logic [$clog2(CAP_LEN+1)-1:0] cap_len
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R5: wake request only falls after a frame's last beat
  assert_pme_after_eof_R5: assert property (@(posedge clk) disable iff (rst || !seen)
    $fell(pme_n) |-> $past(in_valid && in_eof));

  // R5: clear without a competing frame end releases the request
  assert_clear_releases_R5: assert property (@(posedge clk) disable iff (rst)
    (pme_clr && !(in_valid && in_eof)) |=> pme_n);

  // R2: descriptor only on the forwarded last beat
  assert_desc_on_eof_R2: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (out_valid && out_eof));

  // R3: a status word never appears without its descriptor strobe being meaningful
  assert_desc_width_R3: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_status == '0) |-> out_eof);

  // R7: length never past the prefix
  assert_len_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cap_len <= ($clog2(CAP_LEN+1))'(CAP_LEN));

  // R10: captured length frozen while a request is pending
  assert_len_held_R10: assert property (@(posedge clk) disable iff (rst || !seen)
    (!pme_n && $past(!pme_n)) |-> $stable(cap_len));

  // R1: output beats follow input beats
  assert_out_follows_in_R1: assert property (@(posedge clk) disable iff (rst || !seen)
    out_valid |-> $past(in_valid));
endmodule

bind mgmt_rx_classifier mrc_checker #(.CAP_LEN(CAP_LEN), .STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_eof      (in_eof),
  .pme_clr     (pme_clr),
  .out_valid   (out_valid),
  .out_eof     (out_eof),
  .desc_valid  (desc_valid),
  .desc_status (desc_status),
  .pme_n       (pme_n),
  .cap_len     (cap_len)
);

// File: tb/sim_mgmt_rx_classifier.sv
`timescale 1ns/1ps
module sim_mgmt_rx_classifier;
  localparam int CAP = 8;
  localparam int AW  = $clog2(CAP);
  localparam int CW  = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_mgmt = 1'b0;
  logic pwr_down = 1'b0, pme_clr = 1'b0;
  logic [7:0] in_data = '0;
  logic [AW-1:0] cap_rd_addr = '0;
  logic out_valid, out_sof, out_eof, desc_valid, pme_n;
  logic [7:0] out_data, cap_rd_data;
  logic [15:0] desc_status;
  logic [CW-1:0] cap_len;

  int n_tests = 0;
  int n_fail  = 0;
  logic exp_pend = 1'b0;
  int exp_len = 0;
  logic [7:0] mcap [CAP];

  always #2 clk = ~clk;

  mgmt_rx_classifier #(.CAP_LEN(CAP)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_mgmt(in_mgmt), .pwr_down(pwr_down),
    .pme_clr(pme_clr), .cap_rd_addr(cap_rd_addr), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .desc_valid(desc_valid), .desc_status(desc_status), .pme_n(pme_n),
    .cap_len(cap_len), .cap_rd_data(cap_rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'(seed * 16 + i * 3 + 1);
  endfunction

  task automatic verify_buffer();
    for (int a = 0; a < exp_len; a++) begin
      cap_rd_addr = AW'(a);
      @(negedge clk);
      chk(cap_rd_data == mcap[a], "R6 buffer byte", cap_rd_data, mcap[a]);
    end
  endtask

  task automatic send(input int len, input int seed, input bit mgmt, input bit pd,
                      input bit flip, input bit clr_last);
    bit fwd, wake;
    fwd  = !pd;
    wake = pd && mgmt && !exp_pend;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = byte_of(seed, i);
      in_mgmt  = (i == 0) ? mgmt : (flip ? !mgmt : mgmt);
      pwr_down = (i == 0) ? pd : (flip ? !pd : pd);
      pme_clr  = clr_last && (i == len - 1);
      @(negedge clk);
      if (fwd) begin
        chk(out_valid && out_data == byte_of(seed, i), "R1 fwd byte", out_data, byte_of(seed, i));
        chk(out_sof == (i == 0) && out_eof == (i == len - 1), "R1 markers",
            {out_sof, out_eof}, {(i == 0), (i == len - 1)});
        if (i == len - 1) begin
          if (mgmt) chk(desc_valid && desc_status == 16'h010A, "R2 mgmt status", desc_status, 16'h010A);
          else      chk(desc_valid && desc_status == 16'h0000, "R3 plain status", desc_status, 0);
        end else begin
          chk(!desc_valid, "R2 desc only at end", desc_valid, 0);
        end
      end else begin
        chk(!out_valid && !desc_valid, mgmt ? "R4 no forward" : "R8 drop",
            {out_valid, desc_valid}, 0);
      end
      if (wake && i < CAP) mcap[i] = byte_of(seed, i);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; pme_clr = 1'b0;
    if (wake) begin
      exp_pend = 1'b1;
      exp_len  = (len < CAP) ? len : CAP;
    end
    chk(pme_n == !exp_pend, wake ? "R5 wake asserted" : "R8 R10 no new wake", pme_n, !exp_pend);
    chk(int'(cap_len) == exp_len, wake ? "R7 captured length" : "R10 length kept", cap_len, exp_len);
  endtask

  task automatic clear_pme();
    pme_clr = 1'b1;
    @(negedge clk);
    pme_clr = 1'b0;
    exp_pend = 1'b0;
    chk(pme_n == 1'b1, "R5 clear releases", pme_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pme_n == 1'b1 && !out_valid && !desc_valid && cap_len == '0, "R11 reset state",
        {pme_n, out_valid, desc_valid}, 3'b100);

    for (int len = 1; len <= 12; len++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          send(len, len + m * 5 + p * 3, m[0], p[0], 1'b0, 1'b0);
          if (exp_pend) begin
            verify_buffer();
            repeat (3) @(negedge clk);
            chk(pme_n == 1'b0, "R5 request held", pme_n, 0);
            clear_pme();
          end
          @(negedge clk);
        end
      end
    end

    // R9: power state and flag flip after the first beat
    send(5, 7, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    send(6, 9, 1'b1, 1'b1, 1'b1, 1'b0);
    verify_buffer();
    // R10: second wake frame while pending leaves capture intact
    send(10, 11, 1'b1, 1'b1, 1'b0, 1'b0);
    verify_buffer();
    clear_pme();
    // R5: clear on a wake frame's last beat loses to the set
    send(3, 13, 1'b1, 1'b1, 1'b0, 1'b1);
    verify_buffer();
    clear_pme();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule